// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the receive front end of an I2C slave. It brings the SCL and SDA lines into the system clock domain, detects START and STOP conditions and shifts in the byte that follows a START. That byte is compared with a programmable address register and, when general call recognition is switched on, with the fixed all-zero general call address. When the byte matches, the block pulls SDA low for the acknowledge clock, copies the byte into a receive buffer and raises a buffer-full flag. It raises an interrupt flag when the ninth clock ends. Data bytes that follow a matched address are handled the same way.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode, a matching header byte raises an update-address flag. Software then loads the low address byte into the address register and clears the flag before the second address byte can match. A general call seen in 10-bit mode skips the second address byte: the flag stays clear and data reception starts at once. Software reads the receive buffer to tell a general call from a specific address. Flags are cleared through single-cycle pulse inputs.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, sda_oe, buf_full, overflow, irq and addr_update are all 0, and the block ignores the bus until a START.
- R2: In 7-bit mode, a first byte whose bits 7..1 equal addr_reg[7:1] and whose bit 0 (R/W) is 0 is acknowledged (SDA held low during the ninth clock), copied to rx_data and sets buf_full. The same address with R/W = 1 is not acknowledged.
- R3: A byte that completes while buf_full is 1 is not acknowledged, sets overflow and leaves rx_data unchanged.
- R4: irq is set when SCL falls at the end of the ninth clock of an acknowledged byte, is still 0 while that ninth clock is high, and stays set until an irq_clr pulse.
- R5: A one-cycle rx_read pulse clears buf_full. Without such a pulse buf_full stays set.
- R6: The byte 0x00 is acknowledged as a general call only while gc_enable is 1. With gc_enable at 0 and a nonzero addr_reg, it is not acknowledged.
- R7: After a first byte that does not match, the block leaves SDA released for every later byte until the next START.
- R8: In 10-bit mode, a first byte of the form 11110xx0 whose bits 2..1 equal addr_reg[2:1] is acknowledged and sets addr_update.
- R9: In 10-bit mode, the second address byte is acknowledged only if it equals addr_reg and addr_update has been cleared by a ua_clr pulse. Otherwise it is not acknowledged.
- R10: In 10-bit mode with gc_enable at 1, a first byte of 0x00 is acknowledged and leaves addr_update at 0. The next byte is taken as data and acknowledged.
- R11: A START at any point, including in the middle of a byte, restarts address reception with a cleared bit count. After a STOP, sda_oe is 0. sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| addr_reg | input | 8 | Own address register (7-bit: bits 7..1; 10-bit: header, then low byte) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 enables general call recognition |
| rx_read | input | 1 | Pulse: receive buffer read, clears buf_full |
| irq_clr | input | 1 | Pulse: clears irq |
| ovf_clr | input | 1 | Pulse: clears overflow |
| ua_clr | input | 1 | Pulse: clears addr_update |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | Interrupt flag |
| addr_update | output | 1 | Address register must be reloaded for the second 10-bit half |

## Verification
The assertions check the timing rules on every cycle. SDA is switched only while the synchronized SCL is low, and it is released after a STOP. The sticky flags keep their value until their clear pulse arrives. Every acknowledge comes with a buffer load, an overflow never changes the buffer, and the update flag only rises in 10-bit mode. Only the bench scenarios can show the address decisions: which byte values are acknowledged in each mode, that a non-matching address silences the block until a new START, the 10-bit reload order, the general call shortcut, and recovery from a START in the middle of a byte.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR1,
      ST_ADDR2,
      ST_DATA,
      ST_SKIP
   } ar_state_t;

   typedef enum logic [1:0] {
      HIT_NONE,
      HIT_OWN,
      HIT_GC,
      HIT_HDR
   } hit_t;

   localparam logic [4:0] TEN_HDR = 5'b11110;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_d;
   assign scl_fall  = ~scl_s &  scl_d;
   assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
   assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_ar_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [BYTE_W-1:0] addr_reg,
   input  logic              ten_bit,
   input  logic              gc_enable,
   input  logic              second_half,
   output hit_t              hit
);

   logic gc_raw;
   logic own7;
   logic hdr;
   logic low;

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_raw = gc_enable && (byte_in == '0);
      end else begin : g_no_gc
         assign gc_raw = 1'b0;
      end
   endgenerate

   assign own7 = !ten_bit && !byte_in[0]
               && (byte_in[BYTE_W-1:1] == addr_reg[BYTE_W-1:1]);
   assign hdr  = ten_bit && !byte_in[0]
               && (byte_in[BYTE_W-1:BYTE_W-5] == TEN_HDR)
               && (byte_in[BYTE_W-1:1] == addr_reg[BYTE_W-1:1]);
   assign low  = (byte_in == addr_reg);

   always_comb begin
      hit = HIT_NONE;
      if (second_half) begin
         if (low) hit = HIT_OWN;
      end else if (gc_raw) begin
         hit = HIT_GC;
      end else if (own7) begin
         hit = HIT_OWN;
      end else if (hdr) begin
         hit = HIT_HDR;
      end
   end

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
   import i2c_ar_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [BYTE_W-1:0] addr_reg,
   input  logic              ten_bit_mode,
   input  logic              gc_enable,
   input  logic              rx_read,
   input  logic              irq_clr,
   input  logic              ovf_clr,
   input  logic              ua_clr,
   output logic [BYTE_W-1:0] rx_data,
   output logic              buf_full,
   output logic              overflow,
   output logic              irq,
   output logic              addr_update
);

   localparam int CNT_W = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("i2c_addr_recognizer: BYTE_W must be 8");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   i2c_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ar_state_t         state, state_after, next_ok;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              ack_ok;
   logic              accept;
   logic              raise_ua;
   hit_t              hit;

   i2c_addr_match #(.BYTE_W(BYTE_W), .GC_SUPPORT(GC_SUPPORT)) u_match (
      .byte_in(shreg),
      .addr_reg(addr_reg),
      .ten_bit(ten_bit_mode),
      .gc_enable(gc_enable),
      .second_half(state == ST_ADDR2),
      .hit(hit)
   );

   // Decision for the byte just shifted in
   always_comb begin
      accept   = 1'b0;
      raise_ua = 1'b0;
      next_ok  = ST_SKIP;
      unique case (state)
         ST_ADDR1: begin
            if (hit == HIT_OWN || hit == HIT_GC) begin
               accept  = 1'b1;
               next_ok = ST_DATA;
            end else if (hit == HIT_HDR) begin
               accept   = 1'b1;
               raise_ua = 1'b1;
               next_ok  = ST_ADDR2;
            end
         end
         ST_ADDR2: begin
            if (hit == HIT_OWN && !addr_update) begin
               accept  = 1'b1;
               next_ok = ST_DATA;
            end
         end
         ST_DATA: begin
            accept  = 1'b1;
            next_ok = ST_DATA;
         end
         default: begin
            accept  = 1'b0;
            next_ok = ST_SKIP;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         state_after <= ST_SKIP;
         bit_cnt     <= '0;
         shreg       <= '0;
         ack_ok      <= 1'b0;
         sda_oe      <= 1'b0;
         rx_data     <= '0;
         buf_full    <= 1'b0;
         overflow    <= 1'b0;
         irq         <= 1'b0;
         addr_update <= 1'b0;
      end else begin
         if (rx_read) buf_full    <= 1'b0;
         if (irq_clr) irq         <= 1'b0;
         if (ovf_clr) overflow    <= 1'b0;
         if (ua_clr)  addr_update <= 1'b0;

         if (start_det) begin
            state   <= ST_ADDR1;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (scl_rise) begin
               if (bit_cnt < CNT_LAST) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (bit_cnt == CNT_LAST) begin
                  bit_cnt <= CNT_ACK;
               end
            end
            if (scl_fall) begin
               if (bit_cnt == CNT_LAST) begin
                  if (accept && buf_full) begin
                     overflow    <= 1'b1;
                     ack_ok      <= 1'b0;
                     state_after <= ST_SKIP;
                  end else if (accept) begin
                     sda_oe      <= 1'b1;
                     ack_ok      <= 1'b1;
                     rx_data     <= shreg;
                     buf_full    <= 1'b1;
                     state_after <= next_ok;
                     if (raise_ua) addr_update <= 1'b1;
                  end else begin
                     ack_ok      <= 1'b0;
                     state_after <= ST_SKIP;
                  end
               end else if (bit_cnt == CNT_ACK) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  state   <= state_after;
                  if (ack_ok) irq <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/i2c_addr_recognizer_chk.sv
module i2c_addr_recognizer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              stop_det,
   input logic              sda_oe,
   input logic              buf_full,
   input logic              rx_read,
   input logic              irq,
   input logic              irq_clr,
   input logic              overflow,
   input logic [BYTE_W-1:0] rx_data,
   input logic              addr_update,
   input logic              ten_bit_mode
);

   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);

   p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   p_ack_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $rose(buf_full));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> ($stable(rx_data) && !sda_oe));

   p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_bf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && !rx_read) |=> buf_full);

   p_bf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_read |=> (!buf_full || $rose(sda_oe)));

   p_ua_tenbit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_update) |-> ten_bit_mode);

endmodule

bind i2c_addr_recognizer i2c_addr_recognizer_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .scl_s(scl_s),
   .stop_det(stop_det),
   .sda_oe(sda_oe),
   .buf_full(buf_full),
   .rx_read(rx_read),
   .irq(irq),
   .irq_clr(irq_clr),
   .overflow(overflow),
   .rx_data(rx_data),
   .addr_update(addr_update),
   .ten_bit_mode(ten_bit_mode)
);

// File: tb/i2c_addr_recognizer_test.sv
module i2c_addr_recognizer_test;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [7:0] addr_reg = 8'hA4;
   logic       ten_bit_mode = 1'b0;
   logic       gc_enable = 1'b0;
   logic       rx_read = 1'b0;
   logic       irq_clr = 1'b0;
   logic       ovf_clr = 1'b0;
   logic       ua_clr = 1'b0;
   logic [7:0] rx_data;
   logic       buf_full, overflow, irq, addr_update;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;
   bit ack_q[$];
   string tag_q[$];
   event ack_slot;
   logic irq_at_ack;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_addr_recognizer uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .addr_reg(addr_reg), .ten_bit_mode(ten_bit_mode),
      .gc_enable(gc_enable), .rx_read(rx_read), .irq_clr(irq_clr),
      .ovf_clr(ovf_clr), .ua_clr(ua_clr), .rx_data(rx_data),
      .buf_full(buf_full), .overflow(overflow), .irq(irq),
      .addr_update(addr_update)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
      end
   endtask

   // driver: pushes the expected acknowledge into the scoreboard queue
   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      send_bits(b, 8);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      ack_q.push_back(exp_ack);
      tag_q.push_back(req);
      irq_at_ack = irq;
      -> ack_slot;
      wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic pulse_read();  rx_read = 1'b1; wq(1); rx_read = 1'b0; wq(1); endtask
   task automatic pulse_irq();   irq_clr = 1'b1; wq(1); irq_clr = 1'b0; wq(1); endtask
   task automatic pulse_ovf();   ovf_clr = 1'b1; wq(1); ovf_clr = 1'b0; wq(1); endtask
   task automatic pulse_ua();    ua_clr  = 1'b1; wq(1); ua_clr  = 1'b0; wq(1); endtask

   task automatic tidy();
      pulse_read(); pulse_irq(); pulse_ovf(); pulse_ua();
   endtask

   // monitor: pops expected acknowledge and compares with the bus
   initial begin
      forever begin
         @(ack_slot);
         if (ack_q.size() != 0) begin
            check({tag_q.pop_front(), " ack"}, {31'd0, ~sda_bus}, {31'd0, ack_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wq(5);
      // R1 reset state
      check("R1 sda_oe", sda_oe, 0);
      check("R1 buf_full", buf_full, 0);
      check("R1 overflow", overflow, 0);
      check("R1 irq", irq, 0);
      check("R1 addr_update", addr_update, 0);
      rst_n = 1'b1;
      wq(4);

      // R2 / R4 / R5: 7-bit match then a data byte
      bus_start();
      send_byte(8'hA4, 1, "R2");
      check("R4 irq low during ninth clock", irq_at_ack, 0);
      check("R2 rx_data", rx_data, 8'hA4);
      check("R2 buf_full", buf_full, 1);
      check("R4 irq set", irq, 1);
      wq(20);
      check("R5 buf_full held", buf_full, 1);
      check("R4 irq held", irq, 1);
      pulse_read();
      check("R5 buf_full cleared", buf_full, 0);
      pulse_irq();
      check("R4 irq cleared", irq, 0);
      send_byte(8'h3C, 1, "R2 data");
      check("R2 data rx_data", rx_data, 8'h3C);
      bus_stop();
      check("R11 released after stop", sda_oe, 0);
      tidy();

      // R2 read direction not acknowledged
      bus_start();
      send_byte(8'hA5, 0, "R2 rw=1");
      check("R2 rw=1 no irq", irq, 0);
      bus_stop();
      tidy();

      // R7 non-match ignores rest of transfer
      bus_start();
      send_byte(8'h70, 0, "R7 addr");
      send_byte(8'hA4, 0, "R7 later byte");
      check("R7 buf_full", buf_full, 0);
      check("R7 irq", irq, 0);
      bus_stop();
      tidy();

      // R6 general call disabled, then enabled
      bus_start();
      send_byte(8'h00, 0, "R6 gc off");
      bus_stop();
      tidy();
      gc_enable = 1'b1;
      bus_start();
      send_byte(8'h00, 1, "R6 gc on");
      check("R6 rx_data", rx_data, 8'h00);
      check("R6 buf_full", buf_full, 1);
      bus_stop();
      tidy();
      gc_enable = 1'b0;

      // R3 overflow: buffer not read before data byte
      bus_start();
      send_byte(8'hA4, 1, "R3 addr");
      send_byte(8'h11, 0, "R3 data");
      check("R3 overflow", overflow, 1);
      check("R3 rx_data unchanged", rx_data, 8'hA4);
      bus_stop();
      tidy();
      check("R3 overflow cleared", overflow, 0);

      // R8 / R9: 10-bit address with reload
      ten_bit_mode = 1'b1;
      addr_reg = 8'hF2;
      bus_start();
      send_byte(8'hF2, 1, "R8 header");
      check("R8 addr_update", addr_update, 1);
      check("R8 rx_data", rx_data, 8'hF2);
      pulse_read(); pulse_irq();
      addr_reg = 8'h5A;
      pulse_ua();
      send_byte(8'h5A, 1, "R9 low byte");
      check("R9 addr_update stays clear", addr_update, 0);
      check("R9 rx_data", rx_data, 8'h5A);
      pulse_read();
      send_byte(8'h77, 1, "R9 data");
      check("R9 data rx_data", rx_data, 8'h77);
      bus_stop();
      tidy();

      // R9 second half without clearing update flag
      addr_reg = 8'hF2;
      bus_start();
      send_byte(8'hF2, 1, "R9 header");
      pulse_read(); pulse_irq();
      addr_reg = 8'h5A;
      send_byte(8'h5A, 0, "R9 no reload");
      check("R9 no irq", irq, 0);
      bus_stop();
      tidy();

      // R10 10-bit general call
      gc_enable = 1'b1;
      bus_start();
      send_byte(8'h00, 1, "R10 gc");
      check("R10 addr_update", addr_update, 0);
      pulse_read();
      send_byte(8'h99, 1, "R10 data");
      check("R10 rx_data", rx_data, 8'h99);
      bus_stop();
      tidy();
      gc_enable = 1'b0;
      ten_bit_mode = 1'b0;
      addr_reg = 8'hA4;

      // R11 repeated START in the middle of a byte
      bus_start();
      send_bits(8'hE0, 3);
      bus_start();
      send_byte(8'hA4, 1, "R11 after restart");
      check("R11 rx_data", rx_data, 8'hA4);
      bus_stop();
      check("R11 sda_oe after stop", sda_oe, 0);
      tidy();

      wq(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule